// File: doc/BRIEF.md
# Bank Coincidence Sync Pulse Generator

This block produces a system synchronization strobe for a multi-bank clock divider. Two output banks, called A and C here, divide the same fast reference clock by ratios chosen with two-bit selects and a shared range bit. Their frequencies need not be integer multiples of each other. The block keeps its own phase counter at the reference rate, whose period is the least common multiple of the two divide ratios. It drives `sync_n` low for exactly one period of the faster bank. The pulse ends on the reference cycle where the rising edges of both banks coincide.

Configuration and freeze inputs are only adopted at a coincidence boundary. This keeps every level change of `sync_n` on a well-defined reference edge and rules out shortened or stretched pulses. After any ratio change, one full coincidence period passes with the output high before the new pulse pattern starts. A freeze request parks the output low from one boundary to a later one.

Top module: `bank_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sync_n` is 1 after that edge, and the phase count restarts at zero.
- R2: Bank A divides by 4, 6, 8, 12 for `a_sel` = 0, 1, 2, 3 when `vco_direct` is 1, and by twice those values when it is 0. Bank C divides by 2, 4, 6, 8 under the same rule for `c_sel`. The low pulse lasts min(A, C) reference cycles.
- R3: With unequal ratios, the pattern repeats every lcm(A, C) cycles, with phase 0 on the cycle after a coincidence boundary. `sync_n` is low exactly on phases lcm−min(A, C) through lcm−1, so it rises on phase 0.
- R4: With equal ratios, the pattern period is 2·A, with `sync_n` low during the second half of each period.
- R5: The selects are sampled only on the last phase of a period. If they differ from the ratios in use, the new ratios take effect from phase 0, and `sync_n` stays 1 for that entire first period.
- R6: `run_en` is sampled only on the last phase of a period. A sampled 0 holds `sync_n` at 0 for every following period until a sampled 1 releases it at a boundary.
- R7: Outside the pulse window, and when not frozen, `sync_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock shared with the bank dividers |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_direct | input | 1 | Range bit: 1 uses the base ratios, 0 doubles both |
| a_sel | input | 2 | Bank A ratio select |
| c_sel | input | 2 | Bank C ratio select |
| run_en | input | 1 | 1 lets the strobe run, 0 requests a freeze at logic 0 |
| sync_n | output | 1 | Active-low coincidence strobe |

## Verification
The in-line assertions check the following on every cycle:
- The phase count stays inside the current period.
- The selected ratios and the freeze state change only right after a boundary.
- `sync_n` rises only on phase 0 and falls only on phase 0 or at the window start.
- A frozen output stays low, and an output without an established pattern stays high.

The exact window position and width for each of the 32 ratio settings, the restart delay after a change, and freeze or release timing relative to the pulse can only be confirmed by the bench's sweeps. The bench compares each cycle with an arithmetic model built from least common multiples.

// File: rtl/bsync_pkg.sv
// Shared widths, the configuration record and ratio arithmetic for the
// bank coincidence sync generator. Assumes all ratios are at most 24.
package bsync_pkg;

    localparam int DIV_W    = 5;   // holds the largest bank ratio (24)
    localparam int CNT_W    = 7;   // holds the largest coincidence period (48)
    localparam int GCD_STEP = 8;   // Euclid iterations, enough for DIV_W operands

    typedef struct packed {
        logic       direct;   // 1: base ratios, 0: doubled ratios
        logic [1:0] a_sel;
        logic [1:0] c_sel;
    } ratio_cfg_t;

    // Bank A divide ratio in reference cycles
    function automatic logic [DIV_W-1:0] a_ratio(input logic direct, input logic [1:0] sel);
        logic [DIV_W-1:0] base;
        case (sel)
            2'd0:    base = DIV_W'(4);
            2'd1:    base = DIV_W'(6);
            2'd2:    base = DIV_W'(8);
            default: base = DIV_W'(12);
        endcase
        return direct ? base : DIV_W'(base << 1);
    endfunction

    // Bank C divide ratio in reference cycles
    function automatic logic [DIV_W-1:0] c_ratio(input logic direct, input logic [1:0] sel);
        logic [DIV_W-1:0] base;
        base = DIV_W'({sel, 1'b0}) + DIV_W'(2);
        return direct ? base : DIV_W'(base << 1);
    endfunction

    // Least common multiple of two nonzero ratios
    function automatic logic [CNT_W-1:0] ratio_lcm(input logic [DIV_W-1:0] x,
                                                  input logic [DIV_W-1:0] y);
        int a;
        int b;
        int t;
        a = int'(x);
        b = int'(y);
        for (int i = 0; i < GCD_STEP; i++) begin
            if (b != 0) begin
                t = a % b;
                a = b;
                b = t;
            end
        end
        if (a == 0) return '0;
        return CNT_W'((int'(x) / a) * int'(y));
    endfunction

endpackage

// File: rtl/bsync_cfg_latch.sv
// Holds the ratio configuration in use and the "pattern established" flag.
// New selects are adopted only on a period boundary (wrap); a boundary that
// brings a different setting clears the flag for one full period.
module bsync_cfg_latch
    import bsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  ratio_cfg_t cfg_in,
    output ratio_cfg_t cfg_cur,
    output logic       armed,
    output logic       live
);

    // Configuration capture and arming at coincidence boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_cur <= cfg_in;
            armed   <= 1'b0;
        end else if (wrap) begin
            cfg_cur <= cfg_in;
            armed   <= (cfg_in == cfg_cur);
        end
    end

    // Marks cycles with at least one non-reset cycle behind them
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(wrap)) |-> $stable(cfg_cur));

    p_arm_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(armed)) |-> $past(wrap));

endmodule

// File: rtl/bsync_ratio_decode.sv
// Turns the configuration in use into the coincidence period and the fast
// bank period, both in reference cycles. Purely combinational.
module bsync_ratio_decode
    import bsync_pkg::*;
(
    input  ratio_cfg_t       cfg,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] fast_len
);

    logic [DIV_W-1:0] div_a;
    logic [DIV_W-1:0] div_c;

    assign div_a = a_ratio(cfg.direct, cfg.a_sel);
    assign div_c = c_ratio(cfg.direct, cfg.c_sel);

    // Fast period and pattern period; equal ratios use a doubled period
    always_comb begin
        fast_len = (div_a < div_c) ? CNT_W'(div_a) : CNT_W'(div_c);
        if (div_a == div_c) period = CNT_W'({div_a, 1'b0});
        else                period = ratio_lcm(div_a, div_c);
    end

endmodule

// File: rtl/bsync_phase_counter.sv
// Reference-rate phase counter modulo the coincidence period. Assumes the
// period only changes on the cycle after wrap.
module bsync_phase_counter
    import bsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    assign wrap = (count == period - CNT_W'(1));

    // Advance the phase, restarting at zero on the last phase
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= '0;
        else           count <= count + CNT_W'(1);
    end

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count < period);

endmodule

// File: rtl/bsync_shaper.sv
// Registers the strobe so that it reflects the state after each edge: low in
// the last fast period before phase 0, low throughout while frozen, high
// otherwise. The freeze request is adopted only on a boundary.
module bsync_shaper
    import bsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             armed,
    input  logic             live,
    input  logic             run_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] fast_len,
    output logic             sync_n
);

    logic frozen;
    logic frozen_nxt;
    logic window_nxt;

    // Next freeze state and whether the next phase lies in the pulse window
    always_comb begin
        frozen_nxt = wrap ? !run_en : frozen;
        window_nxt = !wrap && armed && ((count + CNT_W'(1)) >= (period - fast_len));
    end

    // Freeze state and registered strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen <= 1'b0;
            sync_n <= 1'b1;
        end else begin
            frozen <= frozen_nxt;
            sync_n <= !frozen_nxt && !window_nxt;
        end
    end

    p_frz_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(wrap)) |-> $stable(frozen));

    p_frozen_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !sync_n);

    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !armed) |-> sync_n);

endmodule

// File: rtl/bank_sync_gen.sv
// Top of the bank coincidence sync generator: marks the coming common rising
// edge of banks A and C with a one-fast-period low pulse on sync_n. Assumes
// both banks are divided from clk and rise together on phase 0.
module bank_sync_gen
    import bsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vco_direct,
    input  logic [1:0] a_sel,
    input  logic [1:0] c_sel,
    input  logic       run_en,
    output logic       sync_n
);

    ratio_cfg_t       cfg_in;
    ratio_cfg_t       cfg_cur;
    logic             armed;
    logic             live;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] fast_len;

    assign cfg_in = '{direct: vco_direct, a_sel: a_sel, c_sel: c_sel};

    bsync_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .cfg_in  (cfg_in),
        .cfg_cur (cfg_cur),
        .armed   (armed),
        .live    (live)
    );

    bsync_ratio_decode u_dec (
        .cfg      (cfg_cur),
        .period   (period),
        .fast_len (fast_len)
    );

    bsync_phase_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .count  (count),
        .wrap   (wrap)
    );

    bsync_shaper u_shp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .armed    (armed),
        .live     (live),
        .run_en   (run_en),
        .count    (count),
        .period   (period),
        .fast_len (fast_len),
        .sync_n   (sync_n)
    );

    p_rise_at_coincidence_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (count == '0));

    p_fall_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> ((count == '0) || (count == period - fast_len)));

endmodule

// File: tb/bank_sync_gen_bench.sv
module bank_sync_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_direct = 1'b1;
    logic [1:0] a_sel = 2'd0;
    logic [1:0] c_sel = 2'd0;
    logic       run_en = 1'b1;
    logic       sync_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bank_sync_gen u_bank_sync_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .vco_direct (vco_direct),
        .a_sel      (a_sel),
        .c_sel      (c_sel),
        .run_en     (run_en),
        .sync_n     (sync_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement arithmetic, written independently of the design
    function automatic int ra(input bit d, input int s);
        int b;
        case (s)
            0: b = 4;
            1: b = 6;
            2: b = 8;
            default: b = 12;
        endcase
        return d ? b : 2 * b;
    endfunction

    function automatic int rc(input bit d, input int s);
        return d ? (2 * s + 2) : (4 * s + 4);
    endfunction

    function automatic int patt_len(input bit d, input int sa, input int sc);
        int x;
        int y;
        x = ra(d, sa);
        y = rc(d, sc);
        if (x == y) return 2 * x;
        for (int m = 1; m <= 64; m++) if (((x * m) % y) == 0) return x * m;
        return 0;
    endfunction

    function automatic int fast_of(input bit d, input int sa, input int sc);
        return (ra(d, sa) < rc(d, sc)) ? ra(d, sa) : rc(d, sc);
    endfunction

    // Reference model state
    int m_k = 0;
    bit m_d = 1'b1;
    int m_a = 0;
    int m_c = 0;
    bit m_armed = 1'b0;
    bit m_frz = 1'b0;
    bit m_sync = 1'b1;

    // Model advances on each edge from requirement rules R1, R3-R7
    always @(posedge clk) begin
        if (!rst_n) begin
            m_k = 0; m_d = vco_direct; m_a = a_sel; m_c = c_sel;
            m_armed = 1'b0; m_frz = 1'b0; m_sync = 1'b1;
        end else begin
            if (m_k == patt_len(m_d, m_a, m_c) - 1) begin
                m_k = 0;
                m_armed = (vco_direct == m_d) && (int'(a_sel) == m_a) && (int'(c_sel) == m_c);
                m_d = vco_direct; m_a = a_sel; m_c = c_sel;
                m_frz = !run_en;
            end else begin
                m_k = m_k + 1;
            end
            m_sync = m_frz ? 1'b0 :
                     !(m_armed && (m_k >= patt_len(m_d, m_a, m_c) - fast_of(m_d, m_a, m_c)));
        end
    end

    // Pulse width bookkeeping for R2
    int  low_run = 0;
    bit  run_frz = 0;
    int  run_fast = 0;

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        string tag;
        if (!done) begin
            if (!rst_n)                 tag = "R1";
            else if (m_frz)             tag = "R6";
            else if (!m_armed)          tag = "R5";
            else if (ra(m_d, m_a) == rc(m_d, m_c)) tag = "R4";
            else if (m_k >= patt_len(m_d, m_a, m_c) - fast_of(m_d, m_a, m_c)) tag = "R3";
            else                        tag = "R7";
            checks++;
            if (sync_n !== m_sync) begin
                failures++;
                $display("FAIL %s sync_n phase=%0d actual=%b expected=%b", tag, m_k, sync_n, m_sync);
            end
            if (rst_n && sync_n === 1'b0) begin
                low_run++;
                if (m_frz) run_frz = 1;
                run_fast = fast_of(m_d, m_a, m_c);
            end else begin
                if (low_run > 0 && !run_frz) begin
                    checks++;   // R2 width equals the faster bank period
                    if (low_run != run_fast) begin
                        failures++;
                        $display("FAIL R2 pulse width actual=%0d expected=%0d", low_run, run_fast);
                    end
                end
                low_run = 0;
                run_frz = 0;
            end
        end
    end

    task automatic setcfg(input bit d, input int sa, input int sc);
        @(negedge clk);
        vco_direct = d;
        a_sel = 2'(sa);
        c_sel = 2'(sc);
    endtask

    task automatic wait_low(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sync_n === 1'b0) return;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R2/R3/R4: every ratio combination in both ranges
        for (int d = 1; d >= 0; d--)
            for (int sa = 0; sa < 4; sa++)
                for (int sc = 0; sc < 4; sc++) begin
                    setcfg(bit'(d), sa, sc);
                    repeat (160) @(negedge clk);
                end
        // R5: change ratios while the pulse is low
        setcfg(1'b1, 1, 0);
        repeat (40) @(negedge clk);
        wait_low(60);
        setcfg(1'b0, 3, 2);
        repeat (120) @(negedge clk);
        // R5: change and revert before a boundary
        setcfg(1'b0, 0, 0);
        setcfg(1'b0, 3, 2);
        repeat (120) @(negedge clk);
        // R6: freeze requested mid-pulse, released at an arbitrary phase
        setcfg(1'b1, 3, 2);
        repeat (60) @(negedge clk);
        wait_low(60);
        run_en = 1'b0;
        repeat (57) @(negedge clk);
        run_en = 1'b1;
        repeat (100) @(negedge clk);
        // R1: reset in mid-run
        setcfg(1'b1, 2, 1);
        repeat (23) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (80) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule